// File: doc/BRIEF.md
# Base-and-Bound Address Translator

This block sits between a processor's address path and memory and turns every program address into a physical address on the fly. Each access adds the program address to a relocation base held in the block. In the same cycle the raw program address is compared against a size limit. An access that falls outside the window, or whose sum would run past the top of the 32-bit space, becomes a trap instead of a memory access.

The base and limit registers are loaded through a small write port. That port is honoured only while the privilege input indicates system mode. A write attempted from user mode leaves both registers untouched and raises a privilege trap.

The result of each cycle is held in a registered response state: idle, grant, limit trap, wrap trap or privilege trap. That state drives the outputs one cycle after the inputs are sampled.

Top module: `bb_translator`

## Requirements
- R1: After reset, base and limit are both zero and every output is low. The first access after reset therefore traps with cause 2'b01.
- R2: An access with `va` below the limit and no carry out of `base + va` gives `pa_valid` = 1 and `pa` = `base + va` one clock after `va_valid` is sampled, with `fault` = 0 and `fault_cause` = 2'b00.
- R3: An access with `va` greater than or equal to the limit gives `fault` = 1, `fault_cause` = 2'b01, `pa_valid` = 0 and `pa` = 0 one clock later.
- R4: An access with `va` below the limit whose sum `base + va` carries out of bit 31 gives `fault` = 1, `fault_cause` = 2'b10, `pa_valid` = 0 and `pa` = 0 one clock later.
- R5: In system mode (`sys_mode` = 1), `wr_en` with `wr_sel` = 0 loads the base and with `wr_sel` = 1 loads the limit. The new value applies to accesses sampled from the next clock onward. An access in the same cycle as the write uses the old value.
- R6: A write attempted with `sys_mode` = 0 changes neither register, and gives `fault` = 1 with `fault_cause` = 2'b11 one clock later.
- R7: The trap causes are ranked privilege (2'b11) over limit (2'b01) over wrap (2'b10). When a user-mode write coincides with an access, the access is dropped (`pa_valid` = 0) and the cause is 2'b11.
- R8: `out_valid` equals `va_valid` delayed by one clock, whether or not that access traps.
- R9: In a cycle after one with no access and no user-mode write, `fault`, `pa_valid`, `pa` and `fault_cause` are all zero.
- R10: Translation and checking do not depend on `sys_mode`; an access in system mode is relocated and checked the same way as one in user mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| va_valid | input | 1 | Program address strobe |
| va | input | 32 | Program (virtual) address |
| sys_mode | input | 1 | 1 = system mode, 0 = user mode |
| wr_en | input | 1 | Register write request |
| wr_sel | input | 1 | 0 = base register, 1 = limit register |
| wr_data | input | 32 | Value to load |
| out_valid | output | 1 | Registered copy of `va_valid` |
| pa_valid | output | 1 | Physical address may be used for memory |
| pa | output | 32 | Physical address, zero unless granted |
| fault | output | 1 | Trap raised for the previous cycle |
| fault_cause | output | 2 | 00 none, 01 limit, 10 wrap, 11 privilege |

## Verification
The hardest case to reach from the ports is the wrap trap. It needs a base in the top part of the address space and an address that is below the limit yet large enough to carry, and uniform random values almost never produce both. The stimulus therefore loads bases from a pool that includes values close to 2^32 and draws addresses near the limit, near the carry point and near the exact edges. It also sets up directed cases: the address one below the limit, the address equal to the limit, a sum of exactly 2^32-1 and a sum of exactly 2^32. A user-mode write in the same cycle as an access, and a system write in the same cycle as an access, are also driven on purpose to check the ranking of causes and the old-value rule.

// File: rtl/bb_pkg.sv
package bb_pkg;
    typedef enum logic [2:0] {
        RESP_IDLE,
        RESP_GRANT,
        RESP_LIMIT_TRAP,
        RESP_WRAP_TRAP,
        RESP_PRIV_TRAP
    } resp_e;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'b00,
        CAUSE_LIMIT = 2'b01,
        CAUSE_WRAP  = 2'b10,
        CAUSE_PRIV  = 2'b11
    } cause_e;
endpackage

// File: rtl/bb_regs.sv
module bb_regs #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sys_mode,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [AW-1:0] wr_data,
    output logic [AW-1:0] base_q,
    output logic [AW-1:0] limit_q,
    output logic          priv_viol
);
    logic wr_ok;

    assign wr_ok     = wr_en && sys_mode;
    assign priv_viol = wr_en && !sys_mode;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            limit_q <= '0;
        end else if (wr_ok) begin
            if (wr_sel) limit_q <= wr_data;
            else        base_q  <= wr_data;
        end
    end
endmodule

// File: rtl/bb_xlate.sv
module bb_xlate #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] va,
    input  logic [AW-1:0] base_q,
    input  logic [AW-1:0] limit_q,
    output logic [AW-1:0] sum,
    output logic          carry,
    output logic          over_limit
);
    logic [AW:0] wide_sum;

    assign wide_sum   = {1'b0, base_q} + {1'b0, va};
    assign sum        = wide_sum[AW-1:0];
    assign carry      = wide_sum[AW];
    assign over_limit = (va >= limit_q);
endmodule

// File: rtl/bb_translator.sv
module bb_translator #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          va_valid,
    input  logic [AW-1:0] va,
    input  logic          sys_mode,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [AW-1:0] wr_data,
    output logic          out_valid,
    output logic          pa_valid,
    output logic [AW-1:0] pa,
    output logic          fault,
    output logic [1:0]    fault_cause
);
    import bb_pkg::*;

    logic [AW-1:0] base_q;
    logic [AW-1:0] limit_q;
    logic          priv_viol;
    logic [AW-1:0] sum;
    logic          carry;
    logic          over_limit;

    resp_e         state_q, state_d;
    logic [AW-1:0] pa_q;
    logic          ov_q;

    bb_regs #(.AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .sys_mode (sys_mode),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .base_q   (base_q),
        .limit_q  (limit_q),
        .priv_viol(priv_viol)
    );

    bb_xlate #(.AW(AW)) u_xlate (
        .va        (va),
        .base_q    (base_q),
        .limit_q   (limit_q),
        .sum       (sum),
        .carry     (carry),
        .over_limit(over_limit)
    );

    // next response: privilege > limit > wrap > grant
    always_comb begin
        if (priv_viol)        state_d = RESP_PRIV_TRAP;
        else if (!va_valid)   state_d = RESP_IDLE;
        else if (over_limit)  state_d = RESP_LIMIT_TRAP;
        else if (carry)       state_d = RESP_WRAP_TRAP;
        else                  state_d = RESP_GRANT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RESP_IDLE;
            pa_q    <= '0;
            ov_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            pa_q    <= sum;
            ov_q    <= va_valid;
        end
    end

    always_comb begin
        out_valid   = ov_q;
        pa_valid    = 1'b0;
        pa          = '0;
        fault       = 1'b0;
        fault_cause = CAUSE_NONE;
        unique case (state_q)
            RESP_IDLE: ;
            RESP_GRANT: begin
                pa_valid = 1'b1;
                pa       = pa_q;
            end
            RESP_LIMIT_TRAP: begin
                fault       = 1'b1;
                fault_cause = CAUSE_LIMIT;
            end
            RESP_WRAP_TRAP: begin
                fault       = 1'b1;
                fault_cause = CAUSE_WRAP;
            end
            RESP_PRIV_TRAP: begin
                fault       = 1'b1;
                fault_cause = CAUSE_PRIV;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bb_translator_chk.sv
module bb_translator_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          va_valid,
    input logic [AW-1:0] va,
    input logic          sys_mode,
    input logic          wr_en,
    input logic          out_valid,
    input logic          pa_valid,
    input logic [AW-1:0] pa,
    input logic          fault,
    input logic [1:0]    fault_cause,
    input logic [AW-1:0] base_q,
    input logic [AW-1:0] limit_q
);
    // R8
    a_r8_valid_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        va_valid |=> out_valid);
    a_r8_idle_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        !va_valid |=> !out_valid);
    // R6
    a_r6_user_write_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sys_mode) |=> (fault && fault_cause == 2'b11 && !pa_valid));
    a_r6_user_write_keeps_regs: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sys_mode) |=> ($stable(base_q) && $stable(limit_q)));
    // R3
    a_r3_limit_respected: assert property (@(posedge clk) disable iff (!rst_n)
        (va_valid && !wr_en && va >= limit_q) |=> (fault && !pa_valid));
    // R2 / R4: a granted address lies inside [base, base+limit)
    a_r2_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        pa_valid |-> (pa >= $past(base_q) && (pa - $past(base_q)) < $past(limit_q)));
    // R9
    a_r9_grant_excludes_fault: assert property (@(posedge clk) disable iff (!rst_n)
        pa_valid |-> (!fault && out_valid && fault_cause == 2'b00));
    a_r9_fault_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (fault_cause != 2'b00));
endmodule

bind bb_translator bb_translator_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .va_valid   (va_valid),
    .va         (va),
    .sys_mode   (sys_mode),
    .wr_en      (wr_en),
    .out_valid  (out_valid),
    .pa_valid   (pa_valid),
    .pa         (pa),
    .fault      (fault),
    .fault_cause(fault_cause),
    .base_q     (base_q),
    .limit_q    (limit_q)
);

// File: tb/tb_bb_translator.sv
module tb_bb_translator;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          va_valid = 1'b0;
    logic [AW-1:0] va = '0;
    logic          sys_mode = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_sel = 1'b0;
    logic [AW-1:0] wr_data = '0;
    logic          out_valid, pa_valid, fault;
    logic [AW-1:0] pa;
    logic [1:0]    fault_cause;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [AW-1:0] m_base = '0;
    logic [AW-1:0] m_limit = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bb_translator #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .va_valid(va_valid), .va(va),
        .sys_mode(sys_mode), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .out_valid(out_valid), .pa_valid(pa_valid), .pa(pa),
        .fault(fault), .fault_cause(fault_cause)
    );

    function automatic logic [1:0] exp_cause(input logic v, input logic [AW-1:0] a,
                                             input logic sm, input logic we);
        logic [AW:0] s;
        s = {1'b0, m_base} + {1'b0, a};
        if (we && !sm)      return 2'b11;
        if (!v)             return 2'b00;
        if (a >= m_limit)   return 2'b01;
        if (s[AW])          return 2'b10;
        return 2'b00;
    endfunction

    function automatic string tag_of(input logic [1:0] c, input logic v);
        case (c)
            2'b01:   return "R3";
            2'b10:   return "R4";
            2'b11:   return "R6/R7";
            default: return v ? "R2" : "R9";
        endcase
    endfunction

    task automatic step(input logic v, input logic [AW-1:0] a, input logic sm,
                        input logic we, input logic sel, input logic [AW-1:0] wd,
                        input string tag);
        logic [1:0]    ec;
        logic          epv;
        logic [AW-1:0] epa;
        string         t;
        @(negedge clk);
        va_valid = v; va = a; sys_mode = sm; wr_en = we; wr_sel = sel; wr_data = wd;
        ec  = exp_cause(v, a, sm, we);
        epv = v && (ec == 2'b00);
        epa = epv ? (m_base + a) : '0;
        t   = (tag == "") ? tag_of(ec, v) : tag;
        if (we && sm) begin
            if (sel) m_limit = wd;
            else     m_base  = wd;
        end
        @(posedge clk);
        #1;
        n_checks++;
        if (out_valid !== v || pa_valid !== epv || pa !== epa ||
            fault !== (ec != 2'b00) || fault_cause !== ec) begin
            n_fail++;
            $display("FAIL %s: got ov=%b pv=%b pa=%h f=%b c=%b, expected ov=%b pv=%b pa=%h f=%b c=%b",
                     t, out_valid, pa_valid, pa, fault, fault_cause,
                     v, epv, epa, (ec != 2'b00), ec);
        end
    endtask

    task automatic sys_write(input logic sel, input logic [AW-1:0] wd);
        step(1'b0, '0, 1'b1, 1'b1, sel, wd, "R5");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got run still active, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_B0B0));
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        n_checks++;
        if (out_valid !== 1'b0 || pa_valid !== 1'b0 || pa !== '0 ||
            fault !== 1'b0 || fault_cause !== 2'b00) begin
            n_fail++;
            $display("FAIL R1: got ov=%b pv=%b pa=%h f=%b c=%b, expected all zero",
                     out_valid, pa_valid, pa, fault, fault_cause);
        end
        @(negedge clk);
        rst_n = 1'b1;
        // R1: zero limit blocks first access
        step(1'b1, 32'h0, 1'b0, 1'b0, 1'b0, '0, "R1");
        // R5: program window
        sys_write(1'b0, 32'h0010_0000);
        sys_write(1'b1, 32'h0000_1000);
        step(1'b1, 32'h0000_0FFF, 1'b0, 1'b0, 1'b0, '0, "R2");
        step(1'b1, 32'h0000_1000, 1'b0, 1'b0, 1'b0, '0, "R3");
        step(1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b0, '0, "R2");
        // R10: system-mode access relocated the same way
        step(1'b1, 32'h0000_0123, 1'b1, 1'b0, 1'b0, '0, "R10");
        step(1'b1, 32'h0000_2000, 1'b1, 1'b0, 1'b0, '0, "R10");
        // R9: idle cycle
        step(1'b0, 32'h0000_0010, 1'b0, 1'b0, 1'b0, '0, "R9");
        // R6: user write ignored, then observe unchanged translation
        step(1'b0, '0, 1'b0, 1'b1, 1'b0, 32'h0AAA_0000, "R6");
        step(1'b0, '0, 1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF, "R6");
        step(1'b1, 32'h0000_0800, 1'b0, 1'b0, 1'b0, '0, "R6");
        step(1'b1, 32'h0000_1000, 1'b0, 1'b0, 1'b0, '0, "R6");
        // R7: user write together with a legal access drops the access
        step(1'b1, 32'h0000_0004, 1'b0, 1'b1, 1'b0, 32'h1, "R7");
        // R5: system write same cycle as access uses old base
        step(1'b1, 32'h0000_0010, 1'b1, 1'b1, 1'b0, 32'h0200_0000, "R5");
        step(1'b1, 32'h0000_0010, 1'b0, 1'b0, 1'b0, '0, "R5");
        // R4: wrap corners
        sys_write(1'b0, 32'hFFFF_F000);
        sys_write(1'b1, 32'h0000_2000);
        step(1'b1, 32'h0000_0FFF, 1'b0, 1'b0, 1'b0, '0, "R4");
        step(1'b1, 32'h0000_1000, 1'b0, 1'b0, 1'b0, '0, "R4");
        // R7: limit outranks wrap
        step(1'b1, 32'h0000_3000, 1'b0, 1'b0, 1'b0, '0, "R7");
        // R8: valid mirrored on trapping access then idle
        step(1'b1, 32'h0000_1800, 1'b0, 1'b0, 1'b0, '0, "R8");
        step(1'b0, 32'h0000_1800, 1'b0, 1'b0, 1'b0, '0, "R8");

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            logic          v, sm, we, sel;
            logic [AW-1:0] a, wd;
            int unsigned   r;
            r   = $urandom % 16;
            v   = ($urandom % 4) != 0;
            sm  = $urandom % 2;
            we  = (r < 3);
            sel = $urandom % 2;
            case ($urandom % 4)
                0: wd = 32'hFFFF_0000 + ($urandom % 32'h1_0000);
                1: wd = $urandom % 32'h4000;
                2: wd = $urandom;
                default: wd = 32'h8000_0000 + ($urandom % 32'h100);
            endcase
            case ($urandom % 5)
                0: a = m_limit + ($urandom % 3) - 1;
                1: a = (32'hFFFF_FFFF - m_base) + ($urandom % 3) - 1;
                2: a = (m_limit == 0) ? 32'h0 : ($urandom % m_limit);
                3: a = $urandom % 32'h4000;
                default: a = $urandom;
            endcase
            step(v, a, sm, we, sel, wd, "");
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule